// File: doc/BRIEF.md
# I2C Status Flag Controller

This block keeps the status flags of an I2C controller that can work as bus master or as addressed slave. It sits between a byte-level shift engine, a bus condition detector and the software register interface. From single-cycle event pulses (byte finished, arbitration lost, address byte received with match qualifiers, START, STOP, missing acknowledge) and from software write strobes, it maintains three flags. The first is an active-low pending flag that marks a byte boundary needing service. The second is a bus-busy flag. The third is the transfer direction.

When the pending flag drops, the block raises a one-cycle interrupt pulse. While the flag stays low, it requests that SCL be held low so that no further clock is generated. In slave operation a STOP raises the interrupt without touching the pending flag. A software START request that arrives while the bus is busy is refused, and the refusal is reported on a strobe. A write to the data or transmit buffer register releases the pending flag only after a fixed countdown. This gives the shift engine time to pick up the new byte.

Top module: `i2c_status_flags`

## Requirements
- R1: While enabled, a byteDone or arbLost pulse drives pendN to 0 at the next clock edge, and irq is high for exactly the one cycle that follows that edge.
- R2: In slave mode (masterMode=0) with addrAny=0, an addrByte pulse drops pendN only when addrMatch or genCall is high in the same cycle. With addrAny=1, any addrByte pulse drops pendN. In master mode addrByte has no effect on pendN.
- R3: swPendWrite with swPendData=1 sets pendN to 1 at the next edge. With swPendData=0 the write leaves pendN unchanged.
- R4: A swDataWrite pulse makes pendN rise exactly DELAY (default 12) edges after the edge that samples it. A new swDataWrite during the countdown restarts it from the full count.
- R5: sclHold is high exactly when pendN is 0.
- R6: After reset, pendN=1, busBusy=0, txDir=0 and irq=0. While enable=0, pendN is forced to 1, busBusy to 0, any countdown is cancelled and no irq is raised.
- R7: startSeen sets busBusy and stopSeen clears it. When both arrive in the same cycle, the clear wins.
- R8: In slave mode a stopSeen pulse raises a one-cycle irq with pendN unchanged. In master mode stopSeen raises no irq.
- R9: In slave mode with addrAny=0, an addrByte pulse qualified by addrMatch or genCall loads txDir with rwBit (1 = transmit, 0 = receive).
- R10: txDir is cleared on arbLost, on stopSeen, on a refused START request, and, in slave mode only, on startSeen or noAck. Clearing wins over any load in the same cycle.
- R11: startReq while busBusy=1 and enable=1 drives startBlocked high in the same cycle and clears txDir at the next edge. startReq while busBusy=0 leaves startBlocked low.
- R12: A hardware pendN clear (R1, R2) in the same cycle as a software set (R3) or a swDataWrite leaves pendN at 0 and starts no countdown.
- R13: When no hardware direction event is present, swDirWrite loads txDir with swDirData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Interface enable control bit |
| masterMode | input | 1 | 1 = master, 0 = slave |
| addrAny | input | 1 | 1 = every address byte raises pending, 0 = only matched or general call |
| byteDone | input | 1 | Pulse: a data byte finished (sent or received) |
| arbLost | input | 1 | Pulse: arbitration lost |
| addrByte | input | 1 | Pulse: an address byte was received |
| addrMatch | input | 1 | Qualifier with addrByte: own slave address matched |
| genCall | input | 1 | Qualifier with addrByte: general call address |
| rwBit | input | 1 | Received R/W bit, valid with addrByte |
| startSeen | input | 1 | Pulse: START condition detected |
| stopSeen | input | 1 | Pulse: STOP condition detected |
| noAck | input | 1 | Pulse: acknowledge not returned |
| startReq | input | 1 | Pulse: software asks for a START |
| swPendWrite | input | 1 | Software write strobe for the pending bit |
| swPendData | input | 1 | Value written to the pending bit |
| swDataWrite | input | 1 | Software write to the data or transmit buffer register |
| swDirWrite | input | 1 | Software write strobe for the direction bit |
| swDirData | input | 1 | Value written to the direction bit |
| pendN | output | 1 | Pending flag, active low |
| busBusy | output | 1 | Bus busy flag |
| txDir | output | 1 | Direction, 1 = transmit |
| irq | output | 1 | One-cycle interrupt request |
| sclHold | output | 1 | Request to hold SCL low |
| startBlocked | output | 1 | START request refused because the bus is busy |

## Verification
The pending flag can be cleared by hardware and set by software in the same cycle, and this collision decides whether the shift engine stalls. The bench drives byteDone together with a software set of the pending bit, and in a separate case byteDone together with a buffer write. It then expects pendN to stay low, with the interrupt pulse present, for longer than the release countdown. The second collision is START with STOP on the bus-busy flag, which is provoked in the vector table and judged by busBusy reading 0 afterwards.

// File: rtl/i2c_flags_pkg.sv
package i2c_flags_pkg;

  // Release countdown applied after a data/transmit buffer write
  localparam int unsigned DefaultDelay = 12;

  // Decoded actions handed from the control decoder to the flag registers
  typedef struct packed {
    logic pendClr;    // hardware drops the pending flag
    logic pendSet;    // software sets the pending flag now
    logic delayLoad;  // start or restart the release countdown
    logic stopIrq;    // slave STOP interrupt
    logic busSet;
    logic busClr;
    logic dirClr;
    logic dirLoad;    // load direction from received R/W
    logic dirVal;
    logic dirSwLoad;  // software direction write
    logic dirSwVal;
  } flagStrobes_t;

endpackage

// File: rtl/i2c_flag_ctrl.sv
module i2c_flag_ctrl
  import i2c_flags_pkg::*;
(
  input  logic         enable,
  input  logic         masterMode,
  input  logic         addrAny,
  input  logic         byteDone,
  input  logic         arbLost,
  input  logic         addrByte,
  input  logic         addrMatch,
  input  logic         genCall,
  input  logic         rwBit,
  input  logic         startSeen,
  input  logic         stopSeen,
  input  logic         noAck,
  input  logic         startReq,
  input  logic         swPendWrite,
  input  logic         swPendData,
  input  logic         swDataWrite,
  input  logic         swDirWrite,
  input  logic         swDirData,
  input  logic         busBusy,
  output flagStrobes_t stb,
  output logic         startBlocked
);

  logic isSlave;
  logic addrQualified;
  logic slaveAddrEvt;
  logic refused;

  assign isSlave       = ~masterMode;
  assign addrQualified = addrMatch | genCall;
  // Address byte that should raise the pending flag in slave mode
  assign slaveAddrEvt  = isSlave & addrByte & (addrAny | addrQualified);
  assign refused       = enable & startReq & busBusy;
  assign startBlocked  = refused;

  always_comb begin
    stb = '0;
    if (enable) begin
      stb.pendClr   = byteDone | arbLost | slaveAddrEvt;
      stb.pendSet   = swPendWrite & swPendData;
      stb.delayLoad = swDataWrite;
      stb.stopIrq   = isSlave & stopSeen;
      stb.busSet    = startSeen;
      stb.busClr    = stopSeen;
      stb.dirClr    = arbLost | stopSeen | refused
                    | (isSlave & (startSeen | noAck));
      stb.dirLoad   = isSlave & ~addrAny & addrByte & addrQualified;
      stb.dirVal    = rwBit;
      stb.dirSwLoad = swDirWrite;
      stb.dirSwVal  = swDirData;
    end
  end

endmodule

// File: rtl/i2c_flag_regs.sv
module i2c_flag_regs
  import i2c_flags_pkg::*;
#(
  parameter int unsigned DELAY = DefaultDelay
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  flagStrobes_t stb,
  output logic         pendN,
  output logic         busBusy,
  output logic         txDir,
  output logic         irq
);

  localparam int unsigned CntW = $clog2(DELAY + 1);
  localparam logic [CntW-1:0] CntLoad = CntW'(DELAY);
  localparam logic [CntW-1:0] CntOne  = CntW'(1);

  logic [CntW-1:0] cnt, cntNext;
  logic            cntFire;
  logic            pendNext, busyNext, dirNext, irqNext;

  assign cntFire = (cnt == CntOne);

  // Countdown: hardware clear or disable cancels, a write (re)loads
  always_comb begin
    if (!enable || stb.pendClr)  cntNext = '0;
    else if (stb.delayLoad)      cntNext = CntLoad;
    else if (cnt != '0)          cntNext = cnt - CntOne;
    else                         cntNext = cnt;
  end

  // Pending flag: disable > hardware clear > software/delayed set
  always_comb begin
    pendNext = pendN;
    if (!enable)                          pendNext = 1'b1;
    else if (stb.pendClr)                 pendNext = 1'b0;
    else if (stb.pendSet || cntFire)      pendNext = 1'b1;
  end

  always_comb begin
    busyNext = busBusy;
    if (!enable || stb.busClr) busyNext = 1'b0;
    else if (stb.busSet)       busyNext = 1'b1;
  end

  always_comb begin
    dirNext = txDir;
    if (stb.dirClr)         dirNext = 1'b0;
    else if (stb.dirLoad)   dirNext = stb.dirVal;
    else if (stb.dirSwLoad) dirNext = stb.dirSwVal;
  end

  assign irqNext = (pendN & ~pendNext) | stb.stopIrq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      pendN   <= 1'b1;
      busBusy <= 1'b0;
      txDir   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      cnt     <= cntNext;
      pendN   <= pendNext;
      busBusy <= busyNext;
      txDir   <= dirNext;
      irq     <= irqNext;
    end
  end

  AST_PEND_FALL_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendN) |-> irq); // R1

  AST_DELAY_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cntFire && !stb.pendClr) |=> pendN); // R4

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (pendN && !busBusy && !irq)); // R6

  AST_HW_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stb.pendClr |=> !pendN); // R12

endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
  import i2c_flags_pkg::*;
#(
  parameter int unsigned DELAY = DefaultDelay
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic masterMode,
  input  logic addrAny,
  input  logic byteDone,
  input  logic arbLost,
  input  logic addrByte,
  input  logic addrMatch,
  input  logic genCall,
  input  logic rwBit,
  input  logic startSeen,
  input  logic stopSeen,
  input  logic noAck,
  input  logic startReq,
  input  logic swPendWrite,
  input  logic swPendData,
  input  logic swDataWrite,
  input  logic swDirWrite,
  input  logic swDirData,
  output logic pendN,
  output logic busBusy,
  output logic txDir,
  output logic irq,
  output logic sclHold,
  output logic startBlocked
);

  flagStrobes_t stb;

  i2c_flag_ctrl u_ctrl (
    .enable      (enable),
    .masterMode  (masterMode),
    .addrAny     (addrAny),
    .byteDone    (byteDone),
    .arbLost     (arbLost),
    .addrByte    (addrByte),
    .addrMatch   (addrMatch),
    .genCall     (genCall),
    .rwBit       (rwBit),
    .startSeen   (startSeen),
    .stopSeen    (stopSeen),
    .noAck       (noAck),
    .startReq    (startReq),
    .swPendWrite (swPendWrite),
    .swPendData  (swPendData),
    .swDataWrite (swDataWrite),
    .swDirWrite  (swDirWrite),
    .swDirData   (swDirData),
    .busBusy     (busBusy),
    .stb         (stb),
    .startBlocked(startBlocked)
  );

  i2c_flag_regs #(.DELAY(DELAY)) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .stb    (stb),
    .pendN  (pendN),
    .busBusy(busBusy),
    .txDir  (txDir),
    .irq    (irq)
  );

  // Stop SCL while a byte boundary waits for service
  assign sclHold = ~pendN;

  AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (enable && stopSeen) |=> !busBusy); // R7

  AST_BLOCK_CLEARS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    startBlocked |=> !txDir); // R11

  AST_SLAVE_STOP_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !masterMode && stopSeen) |=> irq); // R8

  AST_ADDR_LOADS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !masterMode && !addrAny && addrByte && addrMatch
     && !arbLost && !stopSeen && !startSeen && !noAck && !startBlocked)
    |=> (txDir == $past(rwBit))); // R9

endmodule

// File: tb/i2c_status_flags_test.sv
module i2c_status_flags_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 0, masterMode = 0, addrAny = 0, byteDone = 0, arbLost = 0;
  logic addrByte = 0, addrMatch = 0, genCall = 0, rwBit = 0, startSeen = 0;
  logic stopSeen = 0, noAck = 0, startReq = 0, swPendWrite = 0, swPendData = 0;
  logic swDataWrite = 0, swDirWrite = 0, swDirData = 0;
  logic pendN, busBusy, txDir, irq, sclHold, startBlocked;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  i2c_status_flags uut (
    .clk(clk), .rstN(rstN), .enable(enable), .masterMode(masterMode),
    .addrAny(addrAny), .byteDone(byteDone), .arbLost(arbLost),
    .addrByte(addrByte), .addrMatch(addrMatch), .genCall(genCall),
    .rwBit(rwBit), .startSeen(startSeen), .stopSeen(stopSeen), .noAck(noAck),
    .startReq(startReq), .swPendWrite(swPendWrite), .swPendData(swPendData),
    .swDataWrite(swDataWrite), .swDirWrite(swDirWrite), .swDirData(swDirData),
    .pendN(pendN), .busBusy(busBusy), .txDir(txDir), .irq(irq),
    .sclHold(sclHold), .startBlocked(startBlocked)
  );

  // Stimulus bits, msb first:
  // en mst any bd al ab am gc rw st sp na sr pw pd dr dd
  localparam int NV = 22;
  localparam logic [16:0] STIM [NV] = '{
    17'b1_0_0_0_0_0_0_0_0_1_0_0_0_0_0_0_0, // 0  R7 start sets busy
    17'b1_0_0_0_0_1_1_0_1_0_0_0_0_0_0_0_0, // 1  R9 matched address, rw=1
    17'b1_0_0_0_0_0_0_0_0_0_0_0_0_0_0_0_0, // 2  R1 irq single cycle
    17'b1_0_0_0_0_0_0_0_0_0_0_0_0_1_1_0_0, // 3  R3 software set
    17'b1_0_0_0_0_0_0_0_0_0_0_0_0_1_0_0_0, // 4  R3 write 0 ignored
    17'b1_0_0_0_0_1_0_0_0_0_0_0_0_0_0_0_0, // 5  R2 unmatched, addrAny=0
    17'b1_0_1_0_0_1_0_0_0_0_0_0_0_0_0_0_0, // 6  R2 addrAny=1
    17'b1_0_0_0_0_0_0_0_0_0_0_0_0_1_1_0_0, // 7  R3
    17'b1_1_0_0_0_1_1_0_0_0_0_0_0_0_0_0_0, // 8  R2 master ignores address
    17'b1_1_0_1_0_0_0_0_0_0_0_0_0_0_0_0_0, // 9  R1 byte done
    17'b1_1_0_0_0_0_0_0_0_0_0_0_0_1_1_0_0, // 10 R3
    17'b1_1_0_0_0_0_0_0_0_0_1_0_0_0_0_0_0, // 11 R8 master stop, no irq
    17'b1_0_0_0_0_0_0_0_0_1_0_0_0_0_0_0_0, // 12 R7
    17'b1_0_0_0_0_0_0_0_0_0_0_0_0_0_0_1_1, // 13 R13 software direction
    17'b1_0_0_0_0_0_0_0_0_0_0_1_0_0_0_0_0, // 14 R10 slave noAck
    17'b1_0_0_0_0_0_0_0_0_0_1_0_0_0_0_0_0, // 15 R8 slave stop irq
    17'b1_0_0_0_0_0_0_0_0_1_1_0_0_0_0_0_0, // 16 R7 start+stop, stop wins
    17'b1_0_0_0_0_0_0_0_0_1_0_0_0_0_0_0_0, // 17 R7
    17'b1_0_0_0_0_0_0_0_0_0_0_0_0_0_0_1_1, // 18 R13
    17'b1_0_0_0_1_0_0_0_0_0_0_0_0_0_0_0_0, // 19 R10 arbitration lost
    17'b0_0_0_0_0_0_0_0_0_0_0_0_0_0_0_0_0, // 20 R6 disable
    17'b1_0_0_0_0_1_0_1_0_0_0_0_0_0_0_0_0  // 21 R2 general call
  };
  // Expected {pendN, busBusy, txDir, irq} after the vector's edge
  localparam logic [3:0] EXPV [NV] = '{
    4'b1100, 4'b0111, 4'b0110, 4'b1110, 4'b1110, 4'b1110, 4'b0111, 4'b1110,
    4'b1110, 4'b0111, 4'b1110, 4'b1000, 4'b1100, 4'b1110, 4'b1100, 4'b1001,
    4'b1001, 4'b1100, 4'b1110, 4'b0101, 4'b1000, 4'b0001
  };
  localparam int REQN [NV] = '{
    7, 9, 1, 3, 3, 2, 2, 3, 2, 1, 3, 8, 7, 13, 10, 8, 7, 7, 13, 10, 6, 2
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearIns();
    {byteDone, arbLost, addrByte, addrMatch, genCall, rwBit, startSeen, stopSeen,
     noAck, startReq, swPendWrite, swPendData, swDataWrite, swDirWrite, swDirData} = '0;
  endtask

  task automatic drive(input logic [16:0] v);
    {enable, masterMode, addrAny, byteDone, arbLost, addrByte, addrMatch, genCall,
     rwBit, startSeen, stopSeen, noAck, startReq, swPendWrite, swPendData,
     swDirWrite, swDirData} = v;
  endtask

  function automatic logic [3:0] state();
    return {pendN, busBusy, txDir, irq};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    @(negedge clk);
    check("R6 reset", state(), 4'b1000);
    rstN = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      drive(STIM[i]);
      step();
      check($sformatf("R%0d vector %0d", REQN[i], i), state(), EXPV[i]);
      check($sformatf("R5 vector %0d", i), {3'b0, sclHold}, {3'b0, ~EXPV[i][3]});
    end

    // R4: delayed release after a buffer write
    clearIns(); enable = 1; masterMode = 1;
    byteDone = 1; step(); byteDone = 0;
    check("R4 precondition", {3'b0, pendN}, 4'b0000);
    swDataWrite = 1; step(); swDataWrite = 0;
    repeat (11) step();
    check("R4 still low at 11", {3'b0, pendN}, 4'b0000);
    step();
    check("R4 rises at 12", {3'b0, pendN}, 4'b0001);

    // R4: restart on second write
    byteDone = 1; step(); byteDone = 0;
    swDataWrite = 1; step(); swDataWrite = 0;
    repeat (5) step();
    swDataWrite = 1; step(); swDataWrite = 0;
    repeat (11) step();
    check("R4 restart still low", {3'b0, pendN}, 4'b0000);
    step();
    check("R4 restart rises", {3'b0, pendN}, 4'b0001);

    // R12: hardware clear beats software set and buffer write
    byteDone = 1; swPendWrite = 1; swPendData = 1; step(); clearIns();
    check("R12 clear vs set", {2'b0, pendN, irq}, 4'b0001);
    swPendWrite = 1; swPendData = 1; step(); clearIns();
    arbLost = 1; swDataWrite = 1; step(); clearIns();
    repeat (14) step();
    check("R12 clear vs buffer write", {3'b0, pendN}, 4'b0000);

    // R6: disable cancels countdown and releases pending
    swDataWrite = 1; step(); clearIns();
    enable = 0; step();
    check("R6 disabled", {pendN, busBusy, 1'b0, irq}, 4'b1000);
    enable = 1; masterMode = 0;
    byteDone = 1; step(); clearIns();
    repeat (13) step();
    check("R6 countdown cancelled", {3'b0, pendN}, 4'b0000);

    // R11: START refused while busy
    startReq = 1; #1;
    check("R11 idle request not blocked", {3'b0, startBlocked}, 4'b0000);
    step(); clearIns();
    startSeen = 1; step(); clearIns();
    swDirWrite = 1; swDirData = 1; step(); clearIns();
    check("R13 direction set", {2'b0, busBusy, txDir}, 4'b0011);
    masterMode = 1; startReq = 1; #1;
    check("R11 blocked strobe", {3'b0, startBlocked}, 4'b0001);
    step(); clearIns();
    check("R11 direction cleared", {2'b0, busBusy, txDir}, 4'b0010);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule